// File: doc/BRIEF.md
# Per-Bank Refresh Scheduler

This block keeps an eight-bank DRAM refreshed one bank at a time. A free-running interval timer adds one owed refresh to a backlog counter every `INTERVAL_CYC` clock cycles while the block is enabled. The interval is the retention period divided by the total number of refresh commands the whole device needs in that period. For a 32 ms period and 16K commands per bank (128K in total), that is roughly 244 ns.

Owed refreshes go to the banks in strict rotation, so every bank gets the same share. The block asks a command arbiter for a slot with `ref_req` and names the target in `ref_bank`. It holds the request until `ref_gnt` arrives. On a grant, the rotation pointer advances and the refreshed bank enters a lockout of `TRC_CYC` cycles, which is the row cycle time expressed in clocks. During the lockout the bank's bit in `bank_busy` stays high so that the arbiter keeps reads and writes off that bank.

If the arbiter falls so far behind that the backlog would pass `BACKLOG_MAX`, the count saturates and a sticky overflow flag is set.

Top module: `bank_refresh_scheduler`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `ref_req`, `bank_busy` and `backlog_ovf` are 0 and `ref_bank` is 0.
- R2: With `en` held high from reset release, the first `ref_req` appears `INTERVAL_CYC` cycles later. Further owed refreshes accrue every `INTERVAL_CYC` cycles. While `en` is low, no refresh accrues.
- R3: Once raised, `ref_req` stays high, and `ref_bank` stays unchanged, until a cycle in which `ref_gnt` is high.
- R4: Granted refreshes target banks 0, 1, …, `NUM_BANKS`-1 and then wrap back to 0.
- R5: A grant for bank b sets `bank_busy[b]` from the next cycle, for exactly `TRC_CYC` cycles (`TRC_CYC` ≥ 1). The busy bits of the other banks are not affected.
- R6: Each grant retires exactly one owed refresh. Back-to-back grants are accepted on consecutive cycles while refreshes are owed and the target bank is free.
- R7: The backlog saturates at `BACKLOG_MAX`. An accrual while the backlog is at the limit sets `backlog_ovf`, which stays set until reset. After saturation, exactly `BACKLOG_MAX` grants are served.
- R8: A grant and an accrual in the same cycle leave the backlog unchanged.
- R9: `ref_req` is low while the bank named by `ref_bank` is busy, even when refreshes are owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables accrual of owed refreshes |
| ref_req | output | 1 | Refresh slot request to the arbiter |
| ref_gnt | input | 1 | Grant; consumed only while `ref_req` is high |
| ref_bank | output | $clog2(NUM_BANKS) | Bank that the pending request targets |
| bank_busy | output | NUM_BANKS | Per-bank row-cycle lockout in progress |
| backlog_ovf | output | 1 | Sticky backlog overflow flag |

## Verification
The checker watches four things on every cycle. A request stays high with its bank held steady until it is granted. Each grant moves the bank pointer one step around the ring and marks the granted bank busy. No request is ever shown for a busy bank. The overflow flag never clears once set.

Other properties need a counted history and are shown only by the bench scenarios:
- the exact accrual period and the effect of disabling;
- the exact lockout length;
- the backlog arithmetic under a simultaneous grant and accrual;
- the total number of grants served after saturation.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    // Width of an index into a set of n items (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must hold values 0..max.
    function automatic int unsigned cnt_width(int unsigned max);
        return (max > 0) ? $clog2(max + 1) : 1;
    endfunction
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer
    import rfs_pkg::*;
#(
    parameter int unsigned PERIOD = 97
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick_o
);
    localparam int unsigned CW = idx_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = 1'b0;
        if (!en) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            tick_o    = 1'b1;
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog
    import rfs_pkg::*;
#(
    parameter int unsigned MAX_OWED = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic take_i,
    output logic owed_o,
    output logic ovf_o
);
    localparam int unsigned PW = cnt_width(MAX_OWED);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_OWED);

    typedef struct packed {
        logic [PW-1:0] owed;
        logic          ovf;
    } blog_t;

    blog_t bl_d, bl_q;

    always_comb begin
        bl_d = bl_q;
        unique case ({tick_i, take_i})
            2'b10: begin
                if (bl_q.owed == LIMIT) bl_d.ovf  = 1'b1;
                else                    bl_d.owed = bl_q.owed + PW'(1);
            end
            2'b01: begin
                if (bl_q.owed != '0)    bl_d.owed = bl_q.owed - PW'(1);
            end
            default: ; // idle, or accrual and grant cancel out
        endcase
    end

    assign owed_o = (bl_q.owed != '0);
    assign ovf_o  = bl_q.ovf;

    always_ff @(posedge clk) begin
        if (!rst_n) bl_q <= '0;
        else        bl_q <= bl_d;
    end
endmodule

// File: rtl/rfs_bank_lockout.sv
module rfs_bank_lockout
    import rfs_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int unsigned TW = cnt_width(HOLD_CYC);

    typedef struct packed {
        logic [TW-1:0] left;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (load_i)              lk_d.left = TW'(HOLD_CYC);
        else if (lk_q.left != '0) lk_d.left = lk_q.left - TW'(1);
    end

    assign busy_o = (lk_q.left != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end
endmodule

// File: rtl/bank_refresh_scheduler.sv
module bank_refresh_scheduler
    import rfs_pkg::*;
#(
    parameter int unsigned NUM_BANKS    = 8,
    parameter int unsigned INTERVAL_CYC = 97,
    parameter int unsigned TRC_CYC      = 8,
    parameter int unsigned BACKLOG_MAX  = 16,
    localparam int unsigned BW          = idx_width(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    output logic                 ref_req,
    input  logic                 ref_gnt,
    output logic [BW-1:0]        ref_bank,
    output logic [NUM_BANKS-1:0] bank_busy,
    output logic                 backlog_ovf
);
    localparam logic [BW-1:0] LAST_BANK = BW'(NUM_BANKS - 1);

    typedef struct packed {
        logic [BW-1:0] ptr;
    } rr_t;

    rr_t  rr_d, rr_q;
    logic tick;
    logic owed;
    logic take;
    logic [NUM_BANKS-1:0] load;

    rfs_interval_timer #(.PERIOD(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .tick_o (tick)
    );

    rfs_backlog #(.MAX_OWED(BACKLOG_MAX)) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .take_i (take),
        .owed_o (owed),
        .ovf_o  (backlog_ovf)
    );

    always_comb begin
        rr_d    = rr_q;
        ref_req = owed && !bank_busy[rr_q.ptr];
        take    = ref_req && ref_gnt;
        if (take) begin
            rr_d.ptr = (rr_q.ptr == LAST_BANK) ? '0 : rr_q.ptr + BW'(1);
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign load[g] = take && (rr_q.ptr == BW'(g));
        rfs_bank_lockout #(.HOLD_CYC(TRC_CYC)) u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load[g]),
            .busy_o (bank_busy[g])
        );
    end

    assign ref_bank = rr_q.ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end
endmodule

// File: rtl/bank_refresh_scheduler_chk.sv
module bank_refresh_scheduler_chk #(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned BW        = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_req,
    input logic                 ref_gnt,
    input logic [BW-1:0]        ref_bank,
    input logic [NUM_BANKS-1:0] bank_busy,
    input logic                 backlog_ovf
);
    localparam logic [BW-1:0] LAST_BANK = BW'(NUM_BANKS - 1);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_gnt |=> ref_req && $stable(ref_bank));

    // R4
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_gnt |=> ref_bank ==
            (($past(ref_bank) == LAST_BANK) ? '0 : $past(ref_bank) + BW'(1)));

    // R5
    lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_gnt |=> bank_busy[$past(ref_bank)]);

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !bank_busy[ref_bank]);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backlog_ovf |=> backlog_ovf);
endmodule

bind bank_refresh_scheduler bank_refresh_scheduler_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BW        (BW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_req     (ref_req),
    .ref_gnt     (ref_gnt),
    .ref_bank    (ref_bank),
    .bank_busy   (bank_busy),
    .backlog_ovf (backlog_ovf)
);

// File: tb/bank_refresh_scheduler_test.sv
module bank_refresh_scheduler_test;
    localparam int unsigned NB  = 8;
    localparam int unsigned IV  = 10;
    localparam int unsigned TRC = 20;
    localparam int unsigned BL  = 12;
    localparam int unsigned NV  = 10;
    // Each entry: {cycles to hold off the grant [7:4], expected bank [3:0]}
    localparam logic [7:0] VEC [NV] = '{8'h00, 8'h21, 8'h02, 8'h13, 8'h34,
                                        8'h05, 8'h16, 8'h27, 8'h00, 8'h31};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          gnt = 1'b0;
    logic          ref_req;
    logic [2:0]    ref_bank;
    logic [NB-1:0] bank_busy;
    logic          backlog_ovf;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bank_refresh_scheduler #(
        .NUM_BANKS(NB), .INTERVAL_CYC(IV), .TRC_CYC(TRC), .BACKLOG_MAX(BL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .ref_req(ref_req), .ref_gnt(gnt),
        .ref_bank(ref_bank), .bank_busy(bank_busy), .backlog_ovf(backlog_ovf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic en_val);
        @(negedge clk);
        rst_n = 1'b0; gnt = 1'b0; en = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 req in reset", 32'(ref_req), 0);
        check("R1 bank in reset", 32'(ref_bank), 0);
        check("R1 busy in reset", 32'(bank_busy), 0);
        check("R1 ovf in reset", 32'(backlog_ovf), 0);
        en = en_val; rst_n = 1'b1;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!ref_req && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        int hits;

        // R2: disabled means no accrual, then first request after one interval
        do_reset(1'b0);
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ref_req) hits++;
        end
        check("R2 no request while disabled", 32'(hits), 0);
        en = 1'b1;
        wait_req(n);
        check("R2 first request delay", 32'(n), IV);
        // R3: request held without grant
        repeat (3) @(negedge clk);
        check("R3 request held", 32'(ref_req), 1);
        check("R3 bank held", 32'(ref_bank), 0);
        // grant and measure next accrual
        do_reset(1'b1);
        wait_req(n);
        check("R2 request after reset release", 32'(n), IV);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        n = 1;
        while (!ref_req && n < 500) begin
            @(negedge clk);
            n++;
        end
        check("R2 accrual period", 32'(n), IV);

        // R4/R3: table of grants with hold-off delays
        do_reset(1'b1);
        for (int i = 0; i < NV; i++) begin
            wait_req(n);
            for (int h = 0; h < int'(VEC[i][7:4]); h++) begin
                @(negedge clk);
                check("R3 request held during hold-off", 32'(ref_req), 1);
            end
            check("R4 rotation bank", 32'(ref_bank), 32'(VEC[i][3:0]));
            gnt = 1'b1;
            @(negedge clk);
            gnt = 1'b0;
        end

        // R5: lockout length and isolation
        do_reset(1'b1);
        wait_req(n);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        n = 0;
        hits = 0;
        while (bank_busy[0] && n < 100) begin
            if (bank_busy[NB-1:1] != '0) hits++;
            n++;
            @(negedge clk);
        end
        check("R5 lockout length", 32'(n), TRC);
        check("R5 other banks untouched", 32'(hits), 0);

        // R6/R9: back-to-back grants, then blocked by busy bank 0
        do_reset(1'b1);
        repeat (95) @(negedge clk);
        gnt = 1'b1;
        for (int k = 0; k < NB; k++) begin
            check("R6 back-to-back request", 32'(ref_req), 1);
            check("R6 back-to-back bank", 32'(ref_bank), k);
            @(negedge clk);
        end
        check("R9 request withheld for busy bank", 32'(ref_req), 0);
        check("R9 target bank", 32'(ref_bank), 0);
        check("R5 all banks busy", 32'(bank_busy), 32'hFF);
        n = 0;
        while (!ref_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R9 wait for bank 0 release", 32'(n), 13);
        check("R9 bank 0 free when requested", 32'(bank_busy[0]), 0);
        gnt = 1'b0;

        // R8: grant and accrual in the same cycle
        do_reset(1'b1);
        wait_req(n);
        repeat (9) @(negedge clk);
        gnt = 1'b1;
        @(negedge clk);
        check("R8 backlog kept on simultaneous grant", 32'(ref_req), 1);
        check("R8 bank after grant", 32'(ref_bank), 1);
        @(negedge clk);
        gnt = 1'b0;
        check("R8 backlog empty after second grant", 32'(ref_req), 0);

        // R7: saturation and sticky overflow
        do_reset(1'b1);
        repeat (125) @(negedge clk);
        check("R7 no overflow at limit", 32'(backlog_ovf), 0);
        repeat (10) @(negedge clk);
        check("R7 overflow set", 32'(backlog_ovf), 1);
        en = 1'b0;
        gnt = 1'b1;
        hits = 0;
        for (int i = 0; i < 200; i++) begin
            if (ref_req) hits++;
            @(negedge clk);
        end
        gnt = 1'b0;
        check("R7 grants served after saturation", 32'(hits), BL);
        check("R7 overflow sticky", 32'(backlog_ovf), 1);

        // R1: reset clears the overflow
        do_reset(1'b0);
        @(negedge clk);
        check("R1 ovf after release", 32'(backlog_ovf), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule